// File: doc/BRIEF.md
# Bit-String Locate and Test Unit

This block finds one bit in a bit string and returns its value. A request carries a base and a signed bit offset. The base is one of two kinds. It can be a register value, in which case the bit is taken straight from that value. It can also be a byte address in memory, in which case the block works out the byte that holds the bit and the bit's position inside that byte. It then issues exactly one byte read on its memory port and returns the chosen bit once the read data arrives.

For a memory base, the offset is signed. The byte step is the offset divided by eight, rounded toward minus infinity. The bit position is the non-negative remainder. Negative offsets therefore reach bytes below the base, and the bit position always stays in 0..7. A register-base offset outside the register's width produces an error pulse instead of a result.

The unit handles one request at a time. Its idle flag tells the requester when a new request can be taken.

Top module: `bitloc_unit`

## Requirements
- R1: After reset, `res_valid`, `res_err` and `mem_req_valid` are low and `req_ready` is high.
- R2: A register-base request (`req_mem`=0) with an offset in 0..REG_W-1, read as an unsigned number, returns `res_bit` = bit `offset` of `req_reg`, where bit 0 is the least significant bit. `res_valid` is high for one cycle, in the cycle after the request is accepted, and no memory read is issued.
- R3: A register-base request whose offset is outside 0..REG_W-1 (a negative offset counts as outside) raises `res_err` for one cycle, in the cycle after acceptance. `res_valid` stays low. `res_valid` and `res_err` are never high together.
- R4: A memory-base request (`req_mem`=1) presents `mem_req_addr` = (`req_base` + floor(offset/8)) modulo 2^ADDR_W, with the offset taken as a two's-complement number.
- R5: For a memory base, the bit position inside the byte is offset − 8·floor(offset/8), which is always in 0..7. `res_bit` is that bit of `mem_rsp_data`, where bit 0 is the least significant bit.
- R6: `mem_req_valid` rises in the cycle after a memory-base request is accepted. It stays high, with `mem_req_addr` unchanged, until a cycle in which `mem_req_ready` is high, and then drops. Exactly one read is issued per request.
- R7: After the read is accepted, `res_valid` rises in the cycle after `mem_rsp_valid` is high. It stays low before that.
- R8: `req_ready` is low while a memory access is in progress. A request presented during that time is ignored: it produces no result and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_mem | input | 1 | 1 = memory byte-address base, 0 = register base |
| req_reg | input | REG_W | Register-base value |
| req_base | input | ADDR_W | Memory-base byte address |
| req_offset | input | OFS_W | Bit offset, two's complement |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read byte |
| res_valid | output | 1 | Result strobe |
| res_bit | output | 1 | Selected bit value |
| res_err | output | 1 | Register-base offset out of range |

## Verification
The bench builds the unit with REG_W=8, OFS_W=12 and ADDR_W=16. With these values every one of the 4096 memory-base offsets can be swept in turn. That sweep covers both signs of the offset, every remainder, and address wrap below zero and past the top of the 16-bit space. An 8-bit register lets the bench sweep offsets on both sides of the valid 0..7 window, including the most negative and most positive offsets. The request and response delays vary across the sweep, and some stalls carry intruding requests.

// File: rtl/bitloc_pkg.sv
package bitloc_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIDX_W    = $clog2(BYTE_BITS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } loc_state_e;

endpackage

// File: rtl/bitloc_locate.sv
// Splits a signed bit offset into a floored byte step and a non-negative
// bit position, and adds the step to the byte base.
module bitloc_locate
    import bitloc_pkg::*;
#(
    parameter int OFS_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  offset,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [BIDX_W-1:0] bit_idx
);
    logic signed [OFS_W-1:0] step;

    always_comb begin
        // arithmetic shift rounds toward minus infinity
        step      = $signed(offset) >>> BIDX_W;
        byte_addr = base + ADDR_W'(step);
        // low bits give the non-negative remainder in two's complement
        bit_idx   = offset[BIDX_W-1:0];
    end
endmodule

// File: rtl/bitloc_regsel.sv
// Picks a bit from a register operand and flags offsets outside its width.
module bitloc_regsel #(
    parameter int REG_W = 32,
    parameter int OFS_W = 32
) (
    input  logic [REG_W-1:0] reg_val,
    input  logic [OFS_W-1:0] offset,
    output logic             in_range,
    output logic             sel_bit
);
    localparam int IDX_W = $clog2(REG_W);

    logic [IDX_W-1:0] sel;

    generate
        if (OFS_W > IDX_W) begin : g_wide_ofs
            always_comb begin
                in_range = ~|offset[OFS_W-1:IDX_W];
                sel      = offset[IDX_W-1:0];
            end
        end else begin : g_narrow_ofs
            always_comb begin
                in_range = 1'b1;
                sel      = IDX_W'(offset);
            end
        end
    endgenerate

    assign sel_bit = reg_val[sel];
endmodule

// File: rtl/bitloc_unit.sv
module bitloc_unit
    import bitloc_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int OFS_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_mem,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFS_W-1:0]  req_offset,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_data,
    output logic              res_valid,
    output logic              res_bit,
    output logic              res_err
);
    typedef struct packed {
        loc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [BIDX_W-1:0] idx;
        logic              res_valid;
        logic              res_bit;
        logic              res_err;
    } loc_regs_t;

    loc_regs_t st_d, st_q;

    logic [ADDR_W-1:0] loc_addr;
    logic [BIDX_W-1:0] loc_idx;
    logic              reg_ok;
    logic              reg_bit;

    bitloc_locate #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_locate (
        .base      (req_base),
        .offset    (req_offset),
        .byte_addr (loc_addr),
        .bit_idx   (loc_idx)
    );

    bitloc_regsel #(.REG_W(REG_W), .OFS_W(OFS_W)) u_regsel (
        .reg_val  (req_reg),
        .offset   (req_offset),
        .in_range (reg_ok),
        .sel_bit  (reg_bit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        st_d.res_err   = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mem) begin
                        st_d.state = ST_REQ;
                        st_d.addr  = loc_addr;
                        st_d.idx   = loc_idx;
                    end else if (reg_ok) begin
                        st_d.res_valid = 1'b1;
                        st_d.res_bit   = reg_bit;
                    end else begin
                        st_d.res_err = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) st_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    st_d.res_valid = 1'b1;
                    st_d.res_bit   = mem_rsp_data[st_q.idx];
                    st_d.state     = ST_IDLE;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, addr: '0, idx: '0,
                      res_valid: 1'b0, res_bit: 1'b0, res_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = (st_q.state == ST_IDLE);
    assign mem_req_valid = (st_q.state == ST_REQ);
    assign mem_req_addr  = st_q.addr;
    assign res_valid     = st_q.res_valid;
    assign res_bit       = st_q.res_bit;
    assign res_err       = st_q.res_err;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)) // R6
        else $error("read request dropped or address moved");

    AST_RES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_err)) // R3
        else $error("result and error together");

    AST_REG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_mem |=> (res_valid != res_err) && !mem_req_valid) // R2
        else $error("register request did not finish in one cycle");

    AST_RSP_RES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == ST_WAIT && mem_rsp_valid |=> res_valid && req_ready) // R7
        else $error("response did not produce a result");

    AST_BUSY_NREADY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready && !res_valid) // R8
        else $error("ready while busy");

    AST_MEM_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_mem |=> mem_req_valid && !res_valid && !res_err) // R6
        else $error("memory request not issued");
endmodule

// File: tb/bitloc_unit_bench.sv
`timescale 1ns/1ps
module bitloc_unit_bench;
    localparam int REG_W  = 8;
    localparam int OFS_W  = 12;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_mem = 1'b0;
    logic [REG_W-1:0]  req_reg = '0;
    logic [ADDR_W-1:0] req_base = '0;
    logic [OFS_W-1:0]  req_offset = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [7:0]        mem_rsp_data = '0;
    logic              res_valid;
    logic              res_bit;
    logic              res_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bitloc_unit #(.REG_W(REG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_bitloc_unit (
        .clk, .rst_n, .req_valid, .req_ready, .req_mem, .req_reg, .req_base,
        .req_offset, .mem_req_valid, .mem_req_ready, .mem_req_addr,
        .mem_rsp_valid, .mem_rsp_data, .res_valid, .res_bit, .res_err
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return 8'((a * 29) ^ (a >> 5) ^ (a >> 11));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic reg_req(input logic [REG_W-1:0] val, input int off);
        bit in_rng;
        @(negedge clk);
        req_valid = 1'b1; req_mem = 1'b0; req_reg = val; req_offset = OFS_W'(off);
        @(negedge clk);
        req_valid = 1'b0;
        in_rng = (off >= 0) && (off < REG_W);
        if (in_rng) begin
            check(res_valid && !res_err && !mem_req_valid, "R2 strobe", {res_valid, res_err}, 2'b10);
            check(res_bit == val[off], "R2 bit", res_bit, val[off]);
        end else begin
            check(res_err && !res_valid, "R3 error", {res_valid, res_err}, 2'b01);
        end
    endtask

    task automatic mem_req(input logic [ADDR_W-1:0] base, input int off,
                           input int stall, input int lat, input bit intrude);
        int q;
        int r;
        logic [ADDR_W-1:0] exp_addr;
        logic [7:0] byt;
        q = (off < 0) ? (off - 7) / 8 : off / 8;
        r = off - 8 * q;
        exp_addr = ADDR_W'(int'(base) + q);
        byt = mem_byte(exp_addr);
        @(negedge clk);
        req_valid = 1'b1; req_mem = 1'b1; req_base = base; req_offset = OFS_W'(off);
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req_valid && !req_ready, "R6 start", {mem_req_valid, req_ready}, 2'b10);
        check(mem_req_addr == exp_addr, "R4 addr", mem_req_addr, exp_addr);
        check(r >= 0 && r < 8, "R5 range", r, 0);
        for (int s = 0; s < stall; s++) begin
            if (intrude) begin
                req_valid = 1'b1; req_mem = 1'b0; req_reg = 8'hFF; req_offset = '0;
            end
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr, "R6 hold", mem_req_addr, exp_addr);
            check(!req_ready && !res_valid && !res_err, "R8 busy", {req_ready, res_valid, res_err}, 0);
        end
        req_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid, "R6 single read", mem_req_valid, 0);
        for (int l = 0; l < lat; l++) begin
            @(negedge clk);
            check(!res_valid && !mem_req_valid, "R7 early", res_valid, 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = byt;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~byt;
        check(res_valid && !res_err, "R7 result", res_valid, 1);
        check(res_bit == byt[r], "R5 bit", res_bit, byt[r]);
        @(negedge clk);
        check(!res_valid && !res_err && req_ready, "R8 no stray", {res_valid, res_err}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!res_valid && !res_err && !mem_req_valid, "R1 outputs", {res_valid, res_err, mem_req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !res_valid && !res_err && !mem_req_valid, "R1 idle", req_ready, 1);

        for (int v = 0; v < 4; v++) begin
            for (int o = -12; o <= 12; o++) reg_req(8'(8'hA5 ^ (v * 8'h3C)), o);
        end
        reg_req(8'h80, -2048);
        reg_req(8'h80, 2047);
        reg_req(8'h80, 7);
        reg_req(8'h01, 0);

        for (int o = -2048; o < 2048; o++) begin
            mem_req(16'h0010, o, o & 3, (o >> 2) & 1, (o & 7) == 5);
        end
        for (int o = -2048; o < 2048; o += 37) begin
            mem_req(16'hFFF8, o, 1, 2, 1'b0);
        end
        mem_req(16'h0000, -1, 0, 0, 1'b0);
        mem_req(16'hFFFF, 8, 2, 0, 1'b1);
        reg_req(8'h40, 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule